// File: doc/BRIEF.md
# Quadrature Position and Speed Capture Unit

This block turns a two-phase incremental encoder into position and speed readings. An up/down counter follows the encoder in times-four mode: it takes one step on every valid edge of either phase. A free-running timebase runs beside it. One compare register sets the timebase period; the timebase clears when it reaches that value, and the register is called the position period. A second compare register, the speed period, marks a point inside each timebase cycle. When either compare event fires, the current position is copied into a capture register for that event.

The coupling also runs the other way. Each count step of the encoder counter copies the timebase value into a width register, and the value it held before moves into a companion register. Software can therefore get the width of one times-four encoder pulse by taking the difference of the two. Each capture has a sticky flag that software clears.

Top module: `quadPosCapture`

## Requirements
- R1: After synchronisation, with the phase pair written {A,B}, the steps 00→10→11→01→00 each add one to `posCount` and the reverse steps each subtract one.
- R2: A change of both phases between two synchronised samples is an error and leaves `posCount` unchanged.
- R3: `posCount` is 16 bits wide and wraps modulo 65536 in both directions: one down step from 0 gives 0xFFFF.
- R4: A phase change driven just after rising edge k shows on `posCount` after edge k+3 and not earlier.
- R5: The timebase clears in the cycle after it reaches or exceeds the position period (`wrSel`=1) and otherwise adds one, so its period is position period + 1 cycles. After reset the position period is 0xFFFF and the speed period (`wrSel`=0) is 0x7FFF.
- R6: The speed compare fires once per timebase period, when the timebase equals the speed period, and copies `posCount` into `posAtSpeed`.
- R7: The position compare copies `posCount` into `posAtPos`. If a count step happens in the same cycle, the value copied is the one from before that step.
- R8: Each count step copies the timebase into `widthNow` and moves the old `widthNow` into `widthPrev`, so their difference mod 65536 is the number of cycles between steps.
- R9: When a count step and the timebase clear fall in the same cycle, `widthNow` receives the timebase value from before the clear, which equals the position period.
- R10: `capFlags` bit 0 (speed snapshot), bit 1 (position snapshot) and bit 2 (width capture) are set by their capture and stay set until a one is written to the same bit of `flagClr`. A new capture in the same cycle as a clear wins over the clear.
- R11: After reset, the position count, the captures and the flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| phaseA | input | 1 | Encoder phase A, asynchronous |
| phaseB | input | 1 | Encoder phase B, asynchronous |
| wrEn | input | 1 | Period register write strobe |
| wrSel | input | 1 | 0 selects the speed period, 1 selects the position period |
| wrData | input | 16 | Period write value |
| flagClr | input | 3 | Per-bit clear for capFlags |
| posCount | output | 16 | Live encoder position |
| posAtSpeed | output | 16 | Position captured at the speed compare |
| posAtPos | output | 16 | Position captured at the position compare |
| widthNow | output | 16 | Latest timebase capture |
| widthPrev | output | 16 | Previous timebase capture |
| capFlags | output | 3 | Sticky capture flags |

## Verification
The hardest case to reach is a count step that lands exactly in the cycle the timebase clears. At that moment the width capture must take the pre-clear value and the position snapshot must take the pre-step count. The bench first measures the timebase period from the spacing between two sets of the position flag, which fixes its phase against a bench cycle counter. It then drives an encoder edge three edges ahead of the predicted clear, to allow for the synchroniser and edge detection delay.

// File: rtl/encCapPkg.sv
package encCapPkg;
  typedef struct packed {
    logic countPulse;
    logic countUp;
    logic speedHit;
    logic posHit;
  } encStrobe_t;
endpackage

// File: rtl/encCtl.sv
module encCtl
  import encCapPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] POS_RST = '1,
  parameter logic [CNT_W-1:0] SPD_RST = {1'b0, {(CNT_W-1){1'b1}}}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseA,
  input  logic             phaseB,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  output encStrobe_t       strobe,
  output logic [CNT_W-1:0] tbCount
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] shA, shB;
  logic aPrev, bPrev, aNow, bNow, aChg, bChg;
  logic [CNT_W-1:0] posPeriod, speedPeriod;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shA <= '0; shB <= '0; aPrev <= 1'b0; bPrev <= 1'b0;
    end else begin
      shA <= {shA[TOP-1:0], phaseA};
      shB <= {shB[TOP-1:0], phaseB};
      aPrev <= shA[TOP];
      bPrev <= shB[TOP];
    end
  end

  assign aNow = shA[TOP];
  assign bNow = shB[TOP];
  assign aChg = aNow ^ aPrev;
  assign bChg = bNow ^ bPrev;

  always_comb begin
    strobe.countPulse = aChg ^ bChg;
    strobe.countUp    = aNow ^ bPrev;
    strobe.posHit     = (tbCount >= posPeriod);
    strobe.speedHit   = (tbCount == speedPeriod);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posPeriod <= POS_RST;
      speedPeriod <= SPD_RST;
    end else if (wrEn) begin
      if (wrSel) posPeriod <= wrData;
      else       speedPeriod <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              tbCount <= '0;
    else if (strobe.posHit) tbCount <= '0;
    else                    tbCount <= tbCount + 1'b1;
  end

  // R5
  tb_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.posHit |=> tbCount == '0);
  // R5
  tb_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.posHit |=> tbCount == $past(tbCount) + 1'b1);
endmodule

// File: rtl/encDp.sv
module encDp
  import encCapPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_FLAGS = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  encStrobe_t         strobe,
  input  logic [CNT_W-1:0]   tbCount,
  input  logic [N_FLAGS-1:0] flagClr,
  output logic [CNT_W-1:0]   posCount,
  output logic [CNT_W-1:0]   posAtSpeed,
  output logic [CNT_W-1:0]   posAtPos,
  output logic [CNT_W-1:0]   widthNow,
  output logic [CNT_W-1:0]   widthPrev,
  output logic [N_FLAGS-1:0] capFlags
);
  logic [N_FLAGS-1:0] flagSet;

  assign flagSet = {strobe.countPulse, strobe.posHit, strobe.speedHit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posCount <= '0;
    end else if (strobe.countPulse) begin
      posCount <= strobe.countUp ? posCount + 1'b1 : posCount - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posAtSpeed <= '0; posAtPos <= '0; widthNow <= '0; widthPrev <= '0;
    end else begin
      if (strobe.speedHit) posAtSpeed <= posCount;
      if (strobe.posHit)   posAtPos   <= posCount;
      if (strobe.countPulse) begin
        widthPrev <= widthNow;
        widthNow  <= tbCount;
      end
    end
  end

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)           capFlags[i] <= 1'b0;
      else if (flagSet[i]) capFlags[i] <= 1'b1;
      else if (flagClr[i]) capFlags[i] <= 1'b0;
    end
    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (capFlags[i] && !flagClr[i]) |=> capFlags[i]);
  end

  // R1
  pos_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countPulse |=> posCount != $past(posCount));
  // R2
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.countPulse |=> $stable(posCount));
  // R7
  snap_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.posHit |=> posAtPos == $past(posCount));
  // R8
  width_buf_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countPulse |=> (widthPrev == $past(widthNow)) && (widthNow == $past(tbCount)));
endmodule

// File: rtl/quadPosCapture.sv
module quadPosCapture
  import encCapPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseA,
  input  logic             phaseB,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic [2:0]       flagClr,
  output logic [CNT_W-1:0] posCount,
  output logic [CNT_W-1:0] posAtSpeed,
  output logic [CNT_W-1:0] posAtPos,
  output logic [CNT_W-1:0] widthNow,
  output logic [CNT_W-1:0] widthPrev,
  output logic [2:0]       capFlags
);
  encStrobe_t strobe;
  logic [CNT_W-1:0] tbCount;

  encCtl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uCtl (
    .clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .strobe(strobe), .tbCount(tbCount)
  );

  encDp #(.CNT_W(CNT_W), .N_FLAGS(3)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tbCount(tbCount),
    .flagClr(flagClr), .posCount(posCount), .posAtSpeed(posAtSpeed),
    .posAtPos(posAtPos), .widthNow(widthNow), .widthPrev(widthPrev),
    .capFlags(capFlags)
  );
endmodule

// File: tb/tb_quadPosCapture.sv
module tb_quadPosCapture;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic phaseA = 1'b0, phaseB = 1'b0, wrEn = 1'b0, wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic [2:0] flagClr = '0;
  logic [15:0] posCount, posAtSpeed, posAtPos, widthNow, widthPrev;
  logic [2:0] capFlags;
  int total = 0, bad = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  quadPosCapture dut (
    .clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .flagClr(flagClr),
    .posCount(posCount), .posAtSpeed(posAtSpeed), .posAtPos(posAtPos),
    .widthNow(widthNow), .widthPrev(widthPrev), .capFlags(capFlags)
  );

  // {A, B, expected posCount}, walked from state 00 at count 0
  localparam logic [17:0] VEC [8] = '{
    {2'b01, 16'hFFFF}, {2'b00, 16'h0000}, {2'b10, 16'h0001}, {2'b11, 16'h0002},
    {2'b01, 16'h0003}, {2'b00, 16'h0004}, {2'b11, 16'h0004}, {2'b10, 16'h0003}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearFlags(logic [2:0] m);
    flagClr = m;
    @(negedge clk);
    flagClr = '0;
  endtask

  task automatic writePeriod(logic sel, logic [15:0] val);
    wrEn = 1'b1; wrSel = sel; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitFlag(int idx, output int at);
    clearFlags(3'b1 << idx);
    while (!capFlags[idx]) @(negedge clk);
    at = cyc;
  endtask

  initial begin
    int c1, c2, c3, c4, n;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 posCount", posCount, 0);
    chk("R11 captures", {posAtSpeed, posAtPos}, 0);
    chk("R11 widths", {widthNow, widthPrev}, 0);
    chk("R11 flags", capFlags, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R3 table walk, one step every 4 cycles
    for (int i = 0; i < 8; i++) begin
      {phaseA, phaseB} = VEC[i][17:16];
      repeat (4) @(negedge clk);
      chk($sformatf("R1/R2/R3 vec%0d", i), posCount, VEC[i][15:0]);
    end
    // R8 steps 4 cycles apart (last step at vec7; vec6 was an error step)
    chk("R8 width diff table", 16'(widthNow - widthPrev), 8);

    // R4 latency, state 10 -> 11 counts up
    {phaseA, phaseB} = 2'b11;
    repeat (2) @(negedge clk);
    chk("R4 not yet", posCount, 3);
    @(negedge clk);
    chk("R4 after three edges", posCount, 4);
    repeat (4) @(negedge clk);
    {phaseA, phaseB} = 2'b01;
    repeat (4) @(negedge clk);
    chk("R1 count", posCount, 5);
    chk("R8 width diff 7", 16'(widthNow - widthPrev), 7);
    chk("R10 width flag set", capFlags[2], 1);
    clearFlags(3'b100);
    chk("R10 width flag cleared", capFlags[2], 0);

    // R5 R6 period measurement
    writePeriod(1'b1, 16'd40);
    writePeriod(1'b0, 16'd9);
    repeat (3) @(negedge clk);
    waitFlag(1, c1);
    waitFlag(1, c2);
    chk("R5 position period", c2 - c1, 41);
    chk("R7 posAtPos", posAtPos, 5);
    waitFlag(0, c3);
    waitFlag(0, c4);
    chk("R6 speed period", c4 - c3, 41);
    chk("R6 posAtSpeed", posAtSpeed, 5);

    // R9 R7 step coinciding with timebase clear
    waitFlag(1, n);
    while (cyc < n + 38) @(negedge clk);
    {phaseA, phaseB} = 2'b00;
    while (cyc < n + 42) @(negedge clk);
    chk("R9 width pre-clear", widthNow, 40);
    chk("R7 snapshot pre-step", posAtPos, 5);
    chk("R1 count after step", posCount, 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule